// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system use an external asynchronous static RAM of 512K bytes. A client raises a request with a read/write flag, a 19-bit byte address and a byte of write data. The controller takes the request only when it is idle, holds the address and data in registers, and plays out a timed sequence on the memory's active-low chip enable, write enable and output enable. When the access is complete it raises a one-cycle done pulse. For reads, the byte is presented on a registered read-data output at the same time as the pulse.

All memory timings are given as picosecond parameters together with one clock-period parameter. The number of cycles for each phase is worked out at elaboration and rounded up to whole cycles. Each write has three phases, each with its own cycle count. The first is a turnaround phase, in which the memory is selected but output enable stays high, so the memory releases the data bus. The second is a write-enable low phase, during which the controller's data driver is on. The third is a one-cycle hold, in which write enable is high again and the driver is still on. The data bus is split into an output, an input and a tri-state enable; the pad ring joins them. When the controller is idle, all three strobes are high and the memory is in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and whenever idle, chip enable, write enable and output enable are all high (1), the data driver enable is 0, and busy and done are 0.
- R2: A read holds chip enable and output enable low and write enable high for ceil(55 ns / clock period) cycles, which is 6 cycles at the 10 ns default. The byte on the data input is loaded into the read-data output on the clock edge that ends this window.
- R3: A write first holds chip enable low for ceil(20 ns / clock period) cycles (2 at default), with write enable and output enable high and the data driver off.
- R4: Write enable is then low for ceil(max(40 ns, 40 ns, 25 ns) / clock period) cycles (4 at default). The data driver is on from the first of these cycles and drives the registered write byte.
- R5: After write enable rises, chip enable stays low and the driver stays on for exactly one more cycle, and then chip enable rises. A byte written this way reads back unchanged.
- R6: The data driver is never enabled while output enable is low.
- R7: Address and write data are registered when the request is accepted. They do not change while chip enable is low, whatever the request inputs do.
- R8: A request is accepted only while busy is 0. Busy is 1 from the cycle after acceptance until the sequence ends. Requests presented while busy are ignored, and a request still present when the block goes idle is taken with the inputs present at that moment.
- R9: Done is high for exactly one cycle, the cycle after the last active cycle, and busy is 0 in that cycle. Read data changes only together with a read's done pulse.
- R10: The full 19-bit address range is reachable, including address 0 and address 0x7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | A memory cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_out | output | 8 | Data bus value driven by the controller |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_out |
| mem_dq_in | input | 8 | Data bus value seen at the pads |

## Verification
The hardest case to reach is a request that is left asserted across a whole access while its address, data and direction change every cycle. In that case the controller must ignore every intermediate value and then take exactly the value present in the cycle it becomes idle. The bench reaches this by holding the request line high for a long run of cycles while stepping the inputs each cycle. Its reference model accepts only when its own expected schedule is empty. It then reads back every address touched, so that any request accepted at the wrong moment appears as a wrong byte. The same run places a write directly after a read, which exercises the turnaround gap between output enable rising and the driver switching on.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the SRAM access controller.
// Assumes timings are given in picoseconds and are non-negative.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_READ  = 3'd1,
        SEQ_TURN  = 3'd2,
        SEQ_WLOW  = 3'd3,
        SEQ_WHOLD = 3'd4
    } seq_state_e;

    // Whole clock cycles needed to cover t_ps, never fewer than one.
    function automatic int unsigned ceil_cycles(input int unsigned t_ps,
                                                input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    // Largest of three values.
    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_req_latch.sv
`timescale 1ns/1ps
// Request capture register: holds the address and write byte of the accepted
// request for the whole memory cycle. Assumes accept is high for at most one
// cycle per request, and only when the sequencer is idle.
module sram_req_latch #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata
);

    // Load the request fields on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
        end
    end

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
// Access sequencer: a state machine with one shared down-counter that times
// the read window and the three write phases. The strobes are registered from
// the next state, so they change cleanly on clock edges. Assumes every
// cycle-count parameter is at least 1 and fits in CNT_W bits once reduced by 1.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned RD_CYC   = 6,
    parameter int unsigned TURN_CYC = 2,
    parameter int unsigned LOW_CYC  = 4,
    parameter int unsigned HOLD_CYC = 1,
    parameter int unsigned CNT_W    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic accept,
    output logic busy,
    output logic rd_fire,
    output logic wr_fire,
    output logic ce_n,
    output logic we_n,
    output logic oe_n,
    output logic dq_oe
);

    localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] LD_LOW  = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD = CNT_W'(HOLD_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last_cyc;

    assign last_cyc = (cnt_q == '0);
    assign accept   = (state_q == SEQ_IDLE) && req_valid;
    assign busy     = (state_q != SEQ_IDLE);

    // Next-state and counter-reload decode.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rd_fire = 1'b0;
        wr_fire = 1'b0;
        case (state_q)
            SEQ_IDLE: begin
                if (req_valid) begin
                    state_d = req_write ? SEQ_TURN : SEQ_READ;
                    cnt_d   = req_write ? LD_TURN : LD_RD;
                end
            end
            SEQ_READ: begin
                if (last_cyc) begin
                    state_d = SEQ_IDLE;
                    rd_fire = 1'b1;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            SEQ_TURN: begin
                if (last_cyc) begin
                    state_d = SEQ_WLOW;
                    cnt_d   = LD_LOW;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            SEQ_WLOW: begin
                if (last_cyc) begin
                    state_d = SEQ_WHOLD;
                    cnt_d   = LD_HOLD;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            SEQ_WHOLD: begin
                if (last_cyc) begin
                    state_d = SEQ_IDLE;
                    wr_fire = 1'b1;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = SEQ_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Strobes registered from the next state so the pins change only on edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            ce_n  <= (state_d == SEQ_IDLE);
            we_n  <= (state_d != SEQ_WLOW);
            oe_n  <= (state_d != SEQ_READ);
            dq_oe <= (state_d == SEQ_WLOW) || (state_d == SEQ_WHOLD);
        end
    end

    // Checker counters: cycles since output enable went high, and the length
    // of the current write-enable low run.
    logic [CNT_W:0] oe_hi_run;
    logic [CNT_W:0] we_lo_run;

    // Count cycles with output enable high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               oe_hi_run <= '1;
        else if (!oe_n)           oe_hi_run <= '0;
        else if (oe_hi_run != '1) oe_hi_run <= oe_hi_run + (CNT_W+1)'(1);
    end

    // Count cycles with write enable low.
    always_ff @(posedge clk) begin
        if (!rst_n)               we_lo_run <= '0;
        else if (we_n)            we_lo_run <= '0;
        else if (we_lo_run != '1) we_lo_run <= we_lo_run + (CNT_W+1)'(1);
    end

    p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (we_n && oe_n && !dq_oe));

    p_read_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !ce_n));

    p_turnaround_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (oe_hi_run >= (CNT_W+1)'(TURN_CYC)));

    p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_lo_run == (CNT_W+1)'(LOW_CYC)));

    p_drive_after_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (dq_oe && !ce_n));

    p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
// Read-data register and completion pulse. The byte on the pads is taken on
// the edge that ends the read window. Done follows any sequence end by one
// edge. Assumes rd_fire and wr_fire are never high together.
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire,
    input  logic              wr_fire,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    // Capture the read byte at the end of the read window.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (rd_fire) rd_data <= dq_in;
    end

    // One-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= rd_fire || wr_fire;
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_rdata_only_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done);

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM access controller. Converts picosecond timing
// parameters into cycle counts, then connects the request latch, the access
// sequencer and the read capture. Assumes the pads combine mem_dq_out and
// mem_dq_oe into a tri-state driver, and return the pad value on mem_dq_in.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W           = 19,
    parameter int unsigned DATA_W           = 8,
    parameter int unsigned CLK_PERIOD_PS    = 10000,
    parameter int unsigned T_READ_PS        = 55000,
    parameter int unsigned T_RELEASE_PS     = 20000,
    parameter int unsigned T_WE_PULSE_PS    = 40000,
    parameter int unsigned T_ADDR_END_PS    = 40000,
    parameter int unsigned T_DATA_SETUP_PS  = 25000,
    parameter int unsigned T_WRITE_CYCLE_PS = 55000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned RD_CYC   = ceil_cycles(T_READ_PS, CLK_PERIOD_PS);
    localparam int unsigned TURN_CYC = ceil_cycles(T_RELEASE_PS, CLK_PERIOD_PS);
    localparam int unsigned LOW_CYC  = ceil_cycles(
        max3(T_WE_PULSE_PS, T_ADDR_END_PS, T_DATA_SETUP_PS), CLK_PERIOD_PS);
    localparam int unsigned WC_CYC   = ceil_cycles(T_WRITE_CYCLE_PS, CLK_PERIOD_PS);
    localparam int unsigned HOLD_CYC = (WC_CYC > TURN_CYC + LOW_CYC) ?
                                       (WC_CYC - TURN_CYC - LOW_CYC) : 1;
    localparam int unsigned MAX_CYC  = max3(RD_CYC, max3(TURN_CYC, LOW_CYC, HOLD_CYC), 1);
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    logic accept;
    logic rd_fire;
    logic wr_fire;

    sram_req_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .lat_addr  (mem_addr),
        .lat_wdata (mem_dq_out)
    );

    sram_seq_fsm #(
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .LOW_CYC  (LOW_CYC),
        .HOLD_CYC (HOLD_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .accept    (accept),
        .busy      (busy),
        .rd_fire   (rd_fire),
        .wr_fire   (wr_fire),
        .ce_n      (mem_ce_n),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .dq_oe     (mem_dq_oe)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_fire (rd_fire),
        .wr_fire (wr_fire),
        .dq_in   (mem_dq_in),
        .rd_data (rd_data),
        .done    (done)
    );

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    p_select_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> busy);

    p_done_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural memory on the pins plus a reference model that builds
// the expected per-cycle strobe schedule from the timing requirements in a
// queue. Outputs are compared at every falling edge.
module sram_async_ctrl_tb;

    localparam int CLK_PERIOD_NS = 10;
    localparam int CLK_PS = CLK_PERIOD_NS * 1000;
    localparam int N_RD   = (55000 + CLK_PS - 1) / CLK_PS;
    localparam int N_TURN = (20000 + CLK_PS - 1) / CLK_PS;
    localparam int N_LOW  = (40000 + CLK_PS - 1) / CLK_PS;
    localparam int N_WC   = (55000 + CLK_PS - 1) / CLK_PS;
    localparam int N_HOLD = (N_WC > N_TURN + N_LOW) ? (N_WC - N_TURN - N_LOW) : 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done;
    logic [7:0]  rd_data;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    always #(CLK_PERIOD_NS/2) clk = ~clk;

    sram_async_ctrl #(.CLK_PERIOD_PS(CLK_PS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    function automatic logic [7:0] init_val(input logic [18:0] a);
        return a[7:0] ^ a[18:11] ^ 8'h3C;
    endfunction

    // Behavioural memory driven only from the pins.
    logic [7:0] mem_arr [int];
    logic       we_prev = 1'b1;
    always @(negedge clk) begin
        if (!we_prev && mem_we_n && !mem_ce_n && mem_dq_oe)
            mem_arr[int'(mem_addr)] = mem_dq_out;
        we_prev = mem_we_n;
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_in = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)]
                                                       : init_val(mem_addr);
        else
            mem_dq_in = 8'hEE;
    end

    // Reference model state.
    typedef struct {
        logic  ce_n, we_n, oe_n, drv, busy, done, rd;
        string tag;
    } vec_t;
    vec_t        exp_q[$];
    logic [7:0]  shadow [int];
    logic [18:0] exp_addr = '0;
    logic [7:0]  exp_wdata = '0;
    logic [7:0]  exp_rd = '0;
    logic [7:0]  pending_rd = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input int n, input logic ce, input logic we, input logic oe,
                        input logic drv, input logic bsy, input logic dn,
                        input logic rd, input string tag);
        for (int i = 0; i < n; i++) begin
            vec_t v;
            v.ce_n = ce; v.we_n = we; v.oe_n = oe; v.drv = drv;
            v.busy = bsy; v.done = dn; v.rd = rd; v.tag = tag;
            exp_q.push_back(v);
        end
    endtask

    // Model acceptance: uses the request inputs present before the edge.
    task automatic accept_model();
        exp_addr  = req_addr;
        exp_wdata = req_wdata;
        if (req_write) begin
            push(N_TURN, 0, 1, 1, 0, 1, 0, 0, "R3");
            push(N_LOW,  0, 0, 1, 1, 1, 0, 0, "R4");
            push(N_HOLD, 0, 1, 1, 1, 1, 0, 0, "R5");
            push(1,      1, 1, 1, 0, 0, 1, 0, "R9");
            shadow[int'(req_addr)] = req_wdata;
        end else begin
            push(N_RD, 0, 1, 0, 0, 1, 0, 0, "R2");
            push(1,    1, 1, 1, 0, 0, 1, 1, "R9");
            pending_rd = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)]
                                                       : init_val(req_addr);
        end
    endtask

    // One clock: model decides acceptance, then compare at the falling edge.
    task automatic step();
        vec_t v;
        if (exp_q.size() == 0 && req_valid) accept_model();
        @(negedge clk);
        if (exp_q.size() == 0) begin
            v.ce_n = 1; v.we_n = 1; v.oe_n = 1; v.drv = 0;
            v.busy = 0; v.done = 0; v.rd = 0; v.tag = "R1";
        end else begin
            v = exp_q.pop_front();
        end
        if (v.done && v.rd) exp_rd = pending_rd;
        chk({v.tag, "/ce_n"}, 32'(mem_ce_n), 32'(v.ce_n));
        chk({v.tag, "/we_n"}, 32'(mem_we_n), 32'(v.we_n));
        chk({v.tag, "/oe_n"}, 32'(mem_oe_n), 32'(v.oe_n));
        chk({v.tag, "/drv"},  32'(mem_dq_oe), 32'(v.drv));
        chk("R8/busy",        32'(busy), 32'(v.busy));
        chk("R9/done",        32'(done), 32'(v.done));
        chk("R9/rd_data",     32'(rd_data), 32'(exp_rd));
        chk("R6/contention",  32'(mem_dq_oe && !mem_oe_n), 32'(0));
        if (!v.ce_n) chk("R7/addr", 32'(mem_addr), 32'(exp_addr));
        if (v.drv)   chk("R7/wdata", 32'(mem_dq_out), 32'(exp_wdata));
    endtask

    task automatic drain();
        while (exp_q.size() != 0) step();
    endtask

    task automatic do_access(input logic wr, input logic [18:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        step();
        req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~d;   // inputs move after acceptance (R7)
        drain();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        repeat (3) step();

        // R10: lowest address, unwritten
        do_access(1'b0, 19'h00000, 8'h00);
        chk("R10/low", 32'(rd_data), 32'(init_val(19'h00000)));
        // R5 R10: write and read back the highest address
        do_access(1'b1, 19'h7FFFF, 8'h5A);
        do_access(1'b0, 19'h7FFFF, 8'h00);
        chk("R10/high", 32'(rd_data), 32'h5A);
        do_access(1'b1, 19'h12345, 8'hC3);
        do_access(1'b1, 19'h00000, 8'h01);
        do_access(1'b0, 19'h12345, 8'h00);
        chk("R5/readback", 32'(rd_data), 32'hC3);
        do_access(1'b0, 19'h00000, 8'h00);
        chk("R5/readback0", 32'(rd_data), 32'h01);
        repeat (2) step();

        // R8: request held high, inputs changing every cycle
        req_valid = 1'b1;
        for (int i = 0; i < 40; i++) begin
            req_write = (i % 3) != 0;
            req_addr  = 19'h40000 + 19'(i % 16);
            req_wdata = 8'(i * 7 + 3);
            step();
        end
        req_valid = 1'b0;
        drain();
        // Read back every address touched (R8: only accepted writes landed)
        for (int k = 0; k < 16; k++) begin
            logic [7:0] e;
            e = shadow.exists(32'h40000 + k) ? shadow[32'h40000 + k]
                                             : init_val(19'h40000 + 19'(k));
            do_access(1'b0, 19'h40000 + 19'(k), 8'h00);
            chk("R8/readback", 32'(rd_data), 32'(e));
        end
        repeat (3) step();

        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule